// File: doc/BRIEF.md
# Clock Supply Power Sequencer

This block drives the three enables of a peripheral core's clock tree: the oscillator buffer, the PLL and the gate of the internal clock. Software asks for a new setting by writing a 3-bit request word. The block sends each enable to its pins only in a legal order. For wake-up, software only has to turn the oscillator buffer on. The block then raises the PLL enable by itself, waits a programmable lock time, and gates the internal clock on. Software treats the wake-up as complete when the clock enable reads back as 1.

Shutdown to low-power sleep is allowed only when sleep entry was permitted at initialization. The bus-edge activity flag must also be low when the clock is stopped. The block keeps a minimum gap between gating the clock off and turning the PLL off. It derives that gap from a 60 ns figure and the reference clock period. A PLL-off request that arrives early is held and applied when the gap ends. A request that would break the order is ignored and sets a sticky error flag. Software clears that flag by writing 1 to it.

Top module: `clk_seq_ctrl`

## Requirements
- R1: After an asynchronous reset the state output is 0 (off), all three enables are low, the error flag is low and the activity readback is low.
- R2: In the off or sleep state, a write of request word 3'b001 (bit 0 oscillator, bit 1 PLL, bit 2 clock) raises the oscillator enable on the next edge with state 1. The PLL enable rises one edge later with state 2.
- R3: The clock enable rises exactly LOCK_CYC edges after the PLL enable rose, and the state becomes 3 (run).
- R4: In run, a write of 3'b011 while sleep entry is permitted and the activity input is low drops only the clock enable on the next edge, and the state becomes 4 (stopping).
- R5: In run, a write of 3'b011 while the activity input is high is ignored and sets the error flag.
- R6: In run, a write of 3'b011 while sleep entry is not permitted is ignored and sets the error flag.
- R7: A write of 3'b001 made in state 4 before the gap has elapsed is held. The PLL enable falls exactly GAP_CYC edges after the clock enable fell, with state 5 (sleep). GAP_CYC is ceil(60 ns / reference period), with a minimum of 1.
- R8: A write of 3'b001 made in state 4 after the gap has elapsed drops the PLL enable on the edge that takes the write.
- R9: A write that clears the oscillator enable while the PLL is on, or clears the PLL enable while the clock is on, is ignored and sets the error flag.
- R10: The error flag stays set until the clear input is high on an edge. If an error is set on the same edge as a clear, the error wins.
- R11: In sleep, a write of 3'b000 drops the oscillator enable while the state stays 5. A later write of 3'b001 wakes the block through states 1, 2 and 3 again.
- R12: The activity readback output shows the activity input as sampled on the previous edge.
- R13: The clock enable is never high without the PLL enable, and the PLL enable is never high without the oscillator enable.
- R14: In the off or sleep state, a write that sets the PLL or clock bit is ignored and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Request write strobe |
| ctl_wdata | input | 3 | Requested enables: bit 0 oscillator, bit 1 PLL, bit 2 clock |
| err_clr | input | 1 | Write-one clear of the error flag |
| sleep_allow | input | 1 | Sleep entry permitted (set at initialization) |
| act_in | input | 1 | Bus-edge activity flag |
| osc_on | output | 1 | Oscillator buffer enable |
| pll_on | output | 1 | PLL enable |
| clk_on | output | 1 | Internal clock enable |
| state_o | output | 3 | Sequencer state code (0 off, 1 osc, 2 locking, 3 run, 4 stopping, 5 sleep) |
| seq_err | output | 1 | Sticky order-violation flag |
| act_sts | output | 1 | Registered activity readback |

## Verification
The wake path is run twice, once from reset and once from sleep after the oscillator was dropped. These runs tell the lock count apart from a count that starts at the oscillator or ends one edge early. Clock-stop requests are tried with all three gate conditions: permitted, activity high and sleep forbidden. These runs show that each condition blocks the stop alone. PLL-off is requested once inside the gap and once after it, which separates holding the request from applying it at once. The bench also tries each illegal word in each state, and tries a clear on the same edge as a new error, to check that ignored writes leave the enables unchanged.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_OSC   = 3'd1,
    ST_LOCK  = 3'd2,
    ST_RUN   = 3'd3,
    ST_STOP  = 3'd4,
    ST_SLEEP = 3'd5
  } seq_state_e;

  typedef enum logic [2:0] {
    RQ_NONE,
    RQ_WAKE,
    RQ_OSC_OFF,
    RQ_CLK_OFF,
    RQ_PLL_OFF,
    RQ_CLK_ON,
    RQ_BAD
  } req_kind_e;

  // request word bit positions
  localparam int unsigned B_OSC = 0;
  localparam int unsigned B_PLL = 1;
  localparam int unsigned B_CLK = 2;

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // cycles needed to cover a gap in picoseconds, never below one
  function automatic int unsigned gap_cycles(int unsigned gap_ps, int unsigned period_ps);
    int unsigned c;
    c = ceil_div(gap_ps, period_ps);
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/clkseq_down_cnt.sv
module clkseq_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/clkseq_req_decode.sv
module clkseq_req_decode
  import clkseq_pkg::*;
(
  input  seq_state_e st,
  input  logic [2:0] wdata,
  output req_kind_e  kind
);
  always_comb begin
    kind = RQ_BAD;
    unique case (st)
      ST_OFF, ST_SLEEP: begin
        if (wdata == 3'b001)      kind = RQ_WAKE;
        else if (wdata == 3'b000) kind = RQ_OSC_OFF;
        else                      kind = RQ_BAD;
      end
      ST_OSC, ST_LOCK: begin
        // PLL is on or about to come on: the oscillator must stay up
        kind = wdata[B_OSC] ? RQ_NONE : RQ_BAD;
      end
      ST_RUN: begin
        if (wdata == 3'b111)      kind = RQ_NONE;
        else if (wdata == 3'b011) kind = RQ_CLK_OFF;
        else                      kind = RQ_BAD;
      end
      ST_STOP: begin
        if (wdata == 3'b011)      kind = RQ_NONE;
        else if (wdata == 3'b001) kind = RQ_PLL_OFF;
        else if (wdata == 3'b111) kind = RQ_CLK_ON;
        else                      kind = RQ_BAD;
      end
      default: kind = RQ_BAD;
    endcase
  end
endmodule

// File: rtl/clk_seq_ctrl.sv
module clk_seq_ctrl
  import clkseq_pkg::*;
#(
  parameter int unsigned REF_PERIOD_PS = 10000,
  parameter int unsigned STOP_GAP_PS   = 60000,
  parameter int unsigned LOCK_CYC      = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [2:0] ctl_wdata,
  input  logic       err_clr,
  input  logic       sleep_allow,
  input  logic       act_in,
  output logic       osc_on,
  output logic       pll_on,
  output logic       clk_on,
  output logic [2:0] state_o,
  output logic       seq_err,
  output logic       act_sts
);
  localparam int unsigned GAP_CYC = gap_cycles(STOP_GAP_PS, REF_PERIOD_PS);
  localparam int unsigned LOCK_W  = $clog2(LOCK_CYC + 1);
  localparam int unsigned GAP_W   = $clog2(GAP_CYC + 1);

  seq_state_e st_q, st_d;
  logic osc_q, osc_d, pll_q, pll_d, clk_q, clk_d;
  logic err_q, err_d, pend_q, pend_d, act_q;

  req_kind_e kind;
  logic      lock_zero, gap_zero;

  // named internal events
  logic clk_stop_ok, wr_bad, wake_done, gap_done, pll_off_req, pll_off_fire, resume;

  clkseq_req_decode u_dec (
    .st    (st_q),
    .wdata (ctl_wdata),
    .kind  (kind)
  );

  clkseq_down_cnt #(.W(LOCK_W)) u_lock_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (st_q == ST_OSC),
    .load_val (LOCK_W'(LOCK_CYC - 1)),
    .dec      (st_q == ST_LOCK),
    .zero     (lock_zero)
  );

  clkseq_down_cnt #(.W(GAP_W)) u_gap_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl_wr && kind == RQ_CLK_OFF && clk_stop_ok),
    .load_val (GAP_W'(GAP_CYC - 1)),
    .dec      (st_q == ST_STOP),
    .zero     (gap_zero)
  );

  assign clk_stop_ok  = sleep_allow && !act_in;
  assign wr_bad       = ctl_wr && (kind == RQ_BAD || (kind == RQ_CLK_OFF && !clk_stop_ok));
  assign wake_done    = (st_q == ST_LOCK) && lock_zero;
  assign gap_done     = (st_q == ST_STOP) && gap_zero;
  assign resume       = ctl_wr && kind == RQ_CLK_ON;
  assign pll_off_req  = pend_q || (ctl_wr && kind == RQ_PLL_OFF);
  assign pll_off_fire = gap_done && pll_off_req && !resume;

  always_comb begin
    st_d   = st_q;
    osc_d  = osc_q;
    pll_d  = pll_q;
    clk_d  = clk_q;
    pend_d = pend_q;
    unique case (st_q)
      ST_OFF, ST_SLEEP: begin
        if (ctl_wr && kind == RQ_WAKE) begin
          osc_d = 1'b1;
          st_d  = ST_OSC;
        end else if (ctl_wr && kind == RQ_OSC_OFF) begin
          osc_d = 1'b0;
        end
      end
      ST_OSC: begin
        pll_d = 1'b1;
        st_d  = ST_LOCK;
      end
      ST_LOCK: begin
        if (wake_done) begin
          clk_d = 1'b1;
          st_d  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (ctl_wr && kind == RQ_CLK_OFF && clk_stop_ok) begin
          clk_d = 1'b0;
          st_d  = ST_STOP;
        end
      end
      ST_STOP: begin
        if (resume) begin
          clk_d  = 1'b1;
          pend_d = 1'b0;
          st_d   = ST_RUN;
        end else if (pll_off_fire) begin
          pll_d  = 1'b0;
          pend_d = 1'b0;
          st_d   = ST_SLEEP;
        end else if (pll_off_req) begin
          pend_d = 1'b1;
        end
      end
      default: begin
        st_d  = ST_OFF;
        osc_d = 1'b0;
        pll_d = 1'b0;
        clk_d = 1'b0;
      end
    endcase
    if (wr_bad)       err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      osc_q  <= 1'b0;
      pll_q  <= 1'b0;
      clk_q  <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      osc_q  <= osc_d;
      pll_q  <= pll_d;
      clk_q  <= clk_d;
      err_q  <= err_d;
      pend_q <= pend_d;
      act_q  <= act_in;
    end
  end

  assign osc_on  = osc_q;
  assign pll_on  = pll_q;
  assign clk_on  = clk_q;
  assign state_o = st_q;
  assign seq_err = err_q;
  assign act_sts = act_q;
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk #(
  parameter int unsigned LOCK_CYC = 256,
  parameter int unsigned GAP_CYC  = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       err_clr,
  input logic       sleep_allow,
  input logic       act_in,
  input logic       osc_on,
  input logic       pll_on,
  input logic       clk_on,
  input logic [2:0] state_o,
  input logic       seq_err,
  input logic       wake_evt,
  input logic       wr_bad
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 2);
  localparam int unsigned GW = $clog2(GAP_CYC + 2);
  localparam logic [LW-1:0] LSAT = LW'(LOCK_CYC + 1);
  localparam logic [GW-1:0] GSAT = GW'(GAP_CYC + 1);

  logic [LW-1:0] since_pll;
  logic [GW-1:0] since_clkoff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pll    <= '0;
      since_clkoff <= '0;
    end else begin
      if (!pll_on)                since_pll <= '0;
      else if (since_pll != LSAT) since_pll <= since_pll + 1'b1;
      if (clk_on)                       since_clkoff <= '0;
      else if (since_clkoff != GSAT)    since_clkoff <= since_clkoff + 1'b1;
    end
  end

  assert_clk_needs_pll_R13: assert property (@(posedge clk) disable iff (!rst_n)
    clk_on |-> pll_on);
  assert_pll_needs_osc_R13: assert property (@(posedge clk) disable iff (!rst_n)
    pll_on |-> osc_on);
  assert_lock_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_on) |-> since_pll >= LW'(LOCK_CYC));
  assert_wake_gates_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> clk_on && state_o == 3'd3);
  assert_stop_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_on) |-> since_clkoff >= GW'(GAP_CYC));
  assert_no_stop_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_on) |-> !$past(act_in));
  assert_no_stop_unpermitted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_on) |-> $past(sleep_allow));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err && !err_clr |=> seq_err);
  assert_bad_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> seq_err);
  assert_sleep_pll_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd5 |-> !pll_on && !clk_on);
endmodule

bind clk_seq_ctrl clkseq_chk #(.LOCK_CYC(LOCK_CYC), .GAP_CYC(GAP_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_clr     (err_clr),
  .sleep_allow (sleep_allow),
  .act_in      (act_in),
  .osc_on      (osc_on),
  .pll_on      (pll_on),
  .clk_on      (clk_on),
  .state_o     (state_o),
  .seq_err     (seq_err),
  .wake_evt    (wake_done),
  .wr_bad      (wr_bad)
);

// File: tb/clk_seq_ctrl_test.sv
`timescale 1ns/1ps
module clk_seq_ctrl_test;
  localparam int LOCK = 256;
  localparam int GAP  = (60000 + 10000 - 1) / 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = 3'b000;
  logic err_clr = 1'b0;
  logic sleep_allow = 1'b0;
  logic act_in = 1'b0;
  logic osc_on, pll_on, clk_on, seq_err, act_sts;
  logic [2:0] state_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  int         q_due[$];
  logic [7:0] q_val[$];
  string      q_tag[$];

  clk_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .err_clr(err_clr), .sleep_allow(sleep_allow), .act_in(act_in),
    .osc_on(osc_on), .pll_on(pll_on), .clk_on(clk_on), .state_o(state_o),
    .seq_err(seq_err), .act_sts(act_sts)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // expected item: {clk,pll,osc, state, err, act}, due d observation points ahead
  task automatic exp(input int d, input logic [2:0] en, input logic [2:0] st,
                     input logic er, input logic ac, input string tag);
    q_due.push_back(cyc + d);
    q_val.push_back({en, st, er, ac});
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] data);
    ctl_wr = 1'b1;
    ctl_wdata = data;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares due items shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = q_due.size() - 1; i >= 0; i--) begin
        if (q_due[i] == cyc) begin
          logic [7:0] act;
          act = {clk_on, pll_on, osc_on, state_o, seq_err, act_sts};
          checks++;
          if (act !== q_val[i]) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", q_tag[i], cyc, act, q_val[i]);
          end
          q_due.delete(i);
          q_val.delete(i);
          q_tag.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    exp(0, 3'b000, 3'd0, 1'b0, 1'b0, "R1 reset state");

    // R14: PLL bit set while off
    idle(1);
    wr(3'b010);
    exp(0, 3'b000, 3'd0, 1'b1, 1'b0, "R14 pll write while off");
    clr();
    exp(0, 3'b000, 3'd0, 1'b0, 1'b0, "R10 clear error");

    // R2/R3 wake from reset
    wr(3'b001);
    exp(0, 3'b001, 3'd1, 1'b0, 1'b0, "R2 osc up");
    exp(1, 3'b011, 3'd2, 1'b0, 1'b0, "R2 pll auto up");
    exp(LOCK, 3'b011, 3'd2, 1'b0, 1'b0, "R3 still locking");
    exp(LOCK + 1, 3'b111, 3'd3, 1'b0, 1'b0, "R3 R13 clock on after lock");
    idle(LOCK + 2);

    // R9: illegal clears in run
    wr(3'b110);
    exp(0, 3'b111, 3'd3, 1'b1, 1'b0, "R9 osc off with pll on");
    wr(3'b101);
    exp(0, 3'b111, 3'd3, 1'b1, 1'b0, "R9 pll off with clk on");
    clr();

    // R6: sleep not permitted
    wr(3'b011);
    exp(0, 3'b111, 3'd3, 1'b1, 1'b0, "R6 stop refused");
    clr();
    exp(0, 3'b111, 3'd3, 1'b0, 1'b0, "R10 cleared");

    // R5: activity high
    sleep_allow = 1'b1;
    act_in = 1'b1;
    wr(3'b011);
    exp(0, 3'b111, 3'd3, 1'b1, 1'b1, "R5 R12 stop refused while busy");
    act_in = 1'b0;
    clr();
    exp(0, 3'b111, 3'd3, 1'b0, 1'b0, "R12 activity readback low");

    // R4/R7: stop, early PLL-off held
    wr(3'b011);
    exp(0, 3'b011, 3'd4, 1'b0, 1'b0, "R4 clock gated off");
    wr(3'b001);
    exp(GAP - 2, 3'b011, 3'd4, 1'b0, 1'b0, "R7 pll held in gap");
    exp(GAP - 1, 3'b001, 3'd5, 1'b0, 1'b0, "R7 pll off at gap end");
    idle(GAP);

    // R11: osc off in sleep, then wake again
    wr(3'b000);
    exp(0, 3'b000, 3'd5, 1'b0, 1'b0, "R11 osc off in sleep");
    wr(3'b001);
    exp(0, 3'b001, 3'd1, 1'b0, 1'b0, "R11 wake osc");
    exp(1, 3'b011, 3'd2, 1'b0, 1'b0, "R11 wake pll");
    exp(LOCK + 1, 3'b111, 3'd3, 1'b0, 1'b0, "R11 R3 wake clock");
    idle(LOCK + 2);

    // R8: PLL-off after gap applies at once
    wr(3'b011);
    exp(0, 3'b011, 3'd4, 1'b0, 1'b0, "R4 clock gated off again");
    idle(GAP + 1);
    wr(3'b000);
    exp(0, 3'b011, 3'd4, 1'b1, 1'b0, "R9 osc off while stopping");
    clr();
    wr(3'b001);
    exp(0, 3'b001, 3'd5, 1'b0, 1'b0, "R8 pll off immediately");

    // R10: set wins over clear, then sticky, R14 in sleep
    err_clr = 1'b1;
    wr(3'b111);
    err_clr = 1'b0;
    exp(0, 3'b001, 3'd5, 1'b1, 1'b0, "R10 R14 set beats clear");
    idle(3);
    exp(0, 3'b001, 3'd5, 1'b1, 1'b0, "R10 sticky");
    clr();
    exp(0, 3'b001, 3'd5, 1'b0, 1'b0, "R10 cleared");

    // R1: mid-run reset
    idle(1);
    rst_n = 1'b0;
    exp(0, 3'b000, 3'd0, 1'b0, 1'b0, "R1 async reset");
    idle(1);
    rst_n = 1'b1;
    idle(2);

    if (q_due.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual=%0d pending expected=0", q_due.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule